// File: doc/BRIEF.md
# Packed Subword Arithmetic Unit

This block is a 64-bit arithmetic unit that splits each operand word into equal-width lanes and runs the same operation on every lane at once. A two-bit size input selects eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. The bits are the same in every case. The size only decides where carries stop and where clamping and comparison take place.

The supported operations are:
- addition and subtraction, each with a wrapping form, a signed clamping form and an unsigned clamping form;
- an unsigned lane average with unbiased rounding;
- equality and signed greater-than comparisons, which produce all-ones or all-zeros lane masks;
- a shift-and-add that computes a*2^k + b per lane, for multiplying by small constants.

An operation is presented with a valid strobe. Its result is registered and appears one clock later, together with an output strobe.

Top module: `simd_lane_alu`

## Requirements
- R1: Lane size encoding is `lane_sz` 2'b00 = 8-bit lanes, 2'b01 = 16-bit lanes, 2'b10 or 2'b11 = 32-bit lanes (lane i holds bits i*W+W-1 down to i*W). No carry, borrow or comparison result ever crosses a lane boundary.
- R2: When `in_valid` is high at a rising edge, `result` and `out_valid` (high) reflect that operation after that edge. `out_valid` is low after an edge where `in_valid` was low, and `result` holds its value then.
- R3: While `rst_n` is low, `out_valid` and `result` are zero.
- R4: Opcode 0 is lane add and opcode 3 is lane subtract (a-b). Both wrap modulo 2^W.
- R5: Opcodes 1 (add) and 4 (subtract) use signed saturation. A lane that overflows becomes 0x7F..F on positive overflow and 0x80..0 on negative overflow.
- R6: Opcodes 2 (add) and 5 (subtract) use unsigned saturation. A carry out of an add gives all-ones, and a borrow in a subtract gives zero.
- R7: Opcode 6 is the unsigned average. The lane result is the (W+1)-bit sum a+b shifted right by one, with the bit shifted out ORed into the result's least significant bit (round to odd).
- R8: Opcode 7 gives all-ones in a lane when a equals b. Opcode 8 gives all-ones when a is greater than b as signed values. In every other case the lane is all-zeros.
- R9: Opcodes 9, 10 and 11 compute (a << k) + b per lane with k = 1, 2, 3. Bits shifted past the lane top are dropped, and the sum wraps modulo 2^W.
- R10: Opcodes 12 to 15 give an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 4 | Opcode |
| lane_sz | input | 2 | Lane width select |
| opa | input | 64 | Operand a |
| opb | input | 64 | Operand b |
| out_valid | output | 1 | Result strobe |
| result | output | 64 | Registered packed result |

## Verification
The assertions assume that `op`, `lane_sz`, `opa` and `opb` are stable and known whenever `in_valid` is high, and that `in_valid` is low throughout reset. The bench meets this by driving every input only on the falling clock edge and holding the strobe low until reset is released. The lane-range assertions are written for 8-bit lanes only. The stimulus exercises the clamping and comparison opcodes at every lane size, so that each size is checked against the values the bench expects.

// File: rtl/simd_lane_alu.sv
module simd_lane_alu #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [3:0]    op,
  input  logic [1:0]    lane_sz,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  output logic          out_valid,
  output logic [DW-1:0] result
);
  localparam int NSZ = 3;

  logic [DW-1:0] by_size [NSZ];
  logic [DW-1:0] picked;

  for (genvar gi = 0; gi < NSZ; gi++) begin : g_sz
    localparam int W = 8 << gi;
    localparam int NL = DW / W;
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
    logic [DW-1:0] r;

    for (genvar li = 0; li < NL; li++) begin : g_lane
      logic [W-1:0] a, b, bb, wr, y;
      logic [W:0]   s, av;
      logic         sub, ov;

      always_comb begin
        a   = opa[li*W +: W];
        b   = opb[li*W +: W];
        sub = (op == 4'd3) || (op == 4'd4) || (op == 4'd5);
        bb  = sub ? ~b : b;
        s   = {1'b0, a} + {1'b0, bb} + {{W{1'b0}}, sub};
        wr  = s[W-1:0];
        ov  = (a[W-1] == bb[W-1]) && (wr[W-1] != a[W-1]);
        av  = {1'b0, a} + {1'b0, b};
        case (op)
          4'd0, 4'd3:        y = wr;
          4'd1, 4'd4:        y = ov ? (a[W-1] ? SMIN : SMAX) : wr;
          4'd2:              y = s[W] ? {W{1'b1}} : wr;
          4'd5:              y = s[W] ? wr : {W{1'b0}};
          4'd6:              y = av[W:1] | {{(W-1){1'b0}}, av[0]};
          4'd7:              y = {W{a == b}};
          4'd8:              y = {W{$signed(a) > $signed(b)}};
          4'd9, 4'd10, 4'd11: y = (a << op[1:0]) + b;
          default:           y = '0;
        endcase
      end

      assign r[li*W +: W] = y;
    end

    assign by_size[gi] = r;
  end

  assign picked = (lane_sz == 2'd0) ? by_size[0] :
                  (lane_sz == 2'd1) ? by_size[1] : by_size[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= picked;
    end
  end
endmodule

// File: rtl/simd_lane_alu_chk.sv
module simd_lane_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [3:0]  op,
  input logic [1:0]  lane_sz,
  input logic [63:0] opa,
  input logic [63:0] opb,
  input logic        out_valid,
  input logic [63:0] result
);
  function automatic bit bytes_mask(input logic [63:0] r);
    bit ok = 1'b1;
    for (int i = 0; i < 8; i++)
      if (r[i*8 +: 8] != 8'h00 && r[i*8 +: 8] != 8'hFF) ok = 1'b0;
    return ok;
  endfunction

  function automatic bit usat_ge(input logic [63:0] a, input logic [63:0] r);
    bit ok = 1'b1;
    for (int i = 0; i < 8; i++)
      if (r[i*8 +: 8] < a[i*8 +: 8]) ok = 1'b0;
    return ok;
  endfunction

  function automatic bit ssat_sign(input logic [63:0] a, input logic [63:0] b,
                                   input logic [63:0] r);
    bit ok = 1'b1;
    for (int i = 0; i < 8; i++)
      if (a[i*8+7] == b[i*8+7] && r[i*8+7] != a[i*8+7]) ok = 1'b0;
    return ok;
  endfunction

  p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == 4'd7 || op == 4'd8)) |=> bytes_mask(result));
  p_eq_self_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd7 && opa == opb) |=> result == 64'hFFFF_FFFF_FFFF_FFFF);
  p_usat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd2 && lane_sz == 2'd0) |=> usat_ge($past(opa), result));
  p_ssat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd1 && lane_sz == 2'd0) |=> ssat_sign($past(opa), $past(opb), result));
  p_spare_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op[3:2] == 2'b11) |=> result == 64'd0);
endmodule

bind simd_lane_alu simd_lane_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .lane_sz(lane_sz),
  .opa(opa), .opb(opb), .out_valid(out_valid), .result(result)
);

// File: tb/sim_simd_lane_alu.sv
module sim_simd_lane_alu;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  typedef struct packed {
    logic [7:0]  req;
    logic [3:0]  op;
    logic [1:0]  sz;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] e;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{8'd1,  4'd0,  2'd0, 64'hFF01_8070_0000_0001, 64'h0101_8010_0000_00FF, 64'h0002_0080_0000_0000}, // R1 R4
    '{8'd1,  4'd0,  2'd1, 64'hFF01_8070_0000_0001, 64'h0101_8010_0000_00FF, 64'h0002_0080_0000_0100}, // R1
    '{8'd1,  4'd0,  2'd2, 64'hFF01_8070_0000_0001, 64'h0101_8010_0000_00FF, 64'h0003_0080_0000_0100}, // R1
    '{8'd4,  4'd3,  2'd0, 64'h0010_8000_0000_0005, 64'h0001_0001_0000_0007, 64'h000F_80FF_0000_00FE}, // R4
    '{8'd5,  4'd1,  2'd0, 64'h7F80_7F01_40C0_0000, 64'h01FF_8002_40C0_0000, 64'h7F80_FF03_7F80_0000}, // R5
    '{8'd5,  4'd4,  2'd1, 64'h8000_7FFF_0005_FFFF, 64'h0001_FFFF_0007_7FFF, 64'h8000_7FFF_FFFE_8000}, // R5
    '{8'd6,  4'd2,  2'd0, 64'hFF80_0100_F010_FE00, 64'h0180_0100_1010_0100, 64'hFFFF_0200_FF20_FF00}, // R6
    '{8'd6,  4'd5,  2'd2, 64'h0000_0005_FFFF_FFFF, 64'h0000_0006_0000_0001, 64'h0000_0000_FFFF_FFFE}, // R6
    '{8'd7,  4'd6,  2'd0, 64'h0102_FFFF_0003_1080, 64'h0202_FF00_0104_1180, 64'h0102_FF7F_0103_1180}, // R7
    '{8'd7,  4'd6,  2'd1, 64'h0002_FFFF_0000_0004, 64'h0003_FFFF_0000_0001, 64'h0003_FFFF_0000_0003}, // R7
    '{8'd8,  4'd7,  2'd0, 64'h1122_3344_5566_7788, 64'h1100_3300_5500_7700, 64'hFF00_FF00_FF00_FF00}, // R8
    '{8'd8,  4'd8,  2'd1, 64'h0001_8000_7FFF_0005, 64'h0000_0001_8000_0005, 64'hFFFF_0000_FFFF_0000}, // R8
    '{8'd8,  4'd8,  2'd2, 64'hFFFF_FFFF_0000_0002, 64'h0000_0000_0000_0001, 64'h0000_0000_FFFF_FFFF}, // R8
    '{8'd9,  4'd9,  2'd0, 64'h0181_4003_00FF_1000, 64'h0000_0001_0500_F000, 64'h0202_8007_05FE_1000}, // R9
    '{8'd9,  4'd10, 2'd1, 64'h0001_4000_0003_1234, 64'h0001_0001_0003_0000, 64'h0005_0001_000F_48D0}, // R9
    '{8'd9,  4'd11, 2'd2, 64'h2000_0001_0000_0003, 64'h0000_0000_0000_0003, 64'h0000_0008_0000_001B}, // R9
    '{8'd10, 4'd12, 2'd0, 64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, 64'h0000_0000_0000_0000}, // R10
    '{8'd1,  4'd0,  2'd3, 64'hFF01_8070_0000_0001, 64'h0101_8010_0000_00FF, 64'h0003_0080_0000_0100}  // R1 size 3
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic [1:0]  lane_sz = '0;
  logic [63:0] opa = '0;
  logic [63:0] opb = '0;
  logic        out_valid;
  logic [63:0] result;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_lane_alu u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .lane_sz(lane_sz),
    .opa(opa), .opb(opb), .out_valid(out_valid), .result(result)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] o, input logic [1:0] s,
                       input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    op = o; lane_sz = s; opa = a; opb = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R3 result in reset", result, 64'd0);
    check("R3 out_valid in reset", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].op, VEC[i].sz, VEC[i].a, VEC[i].b);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), result, VEC[i].e);
      check("R2 out_valid one cycle after strobe", {63'd0, out_valid}, 64'd1);
    end

    // R2: idle cycles with changed inputs keep result and drop out_valid
    opa = 64'hDEAD_BEEF_DEAD_BEEF; op = 4'd0;
    @(negedge clk);
    check("R2 out_valid low when idle", {63'd0, out_valid}, 64'd0);
    check("R2 result held when idle", result, VEC[NV-1].e);

    // R5: 32-bit signed clamp both directions
    issue(4'd1, 2'd2, 64'h7FFF_FFFF_8000_0000, 64'h0000_0001_FFFF_FFFF);
    check("R5 32-bit clamp", result, 64'h7FFF_FFFF_8000_0000);

    // R6: 16-bit unsigned add clamp and exact fit
    issue(4'd2, 2'd1, 64'hFFFF_8000_0001_7FFF, 64'h0001_8000_0001_8000);
    check("R6 16-bit clamp", result, 64'hFFFF_FFFF_0002_FFFF);

    // R3: reset in mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R3 result cleared", result, 64'd0);
    rst_n = 1'b1;
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule